// File: doc/BRIEF.md
# Byte-Wide LIFO Stack Buffer

This block is an eight-entry stack of bytes. A single select line decides, on every rising clock edge, whether the block stores a new byte or hands back the newest stored byte. There is no separate enable. Every clock that is not in reset is either a push or a pop. A pop that finds data loads the byte into a registered output. The number of stored bytes drives the two status flags, full and empty.

A push on a full stack and a pop on an empty stack are both dropped without side effects. A surrounding controller can therefore hold the select at one level for longer than the depth allows and still keep the stored data. Reset is synchronous and active high. It empties the stack and clears the output register.

Top module: `byte_stack`

## Requirements
- R1: After a clock edge with `rst` high, `empty` is 1, `full` is 0 and `dout` is 0x00.
- R2: With `rd_wr_sel` at 0 (write) and fewer than 8 bytes stored, the clock edge puts `din` on top of the stack and raises the stored count by one.
- R3: With `rd_wr_sel` at 1 (read) and at least one byte stored, the clock edge loads the top byte into `dout`, removes that byte, and lowers the count by one.
- R4: Bytes leave the stack in the reverse of their arrival order. Writing 0x00 to 0x07 and then reading eight times returns 0x07 down to 0x00.
- R5: `full` is 1 exactly when 8 bytes are stored. It rises on the edge of the eighth accepted write.
- R6: `empty` is 1 exactly when no byte is stored. It rises on the edge of the read that takes the last byte.
- R7: A write while `full` is 1 is dropped. The count stays at 8, and the eight stored bytes are unchanged, so later reads still return them.
- R8: A read while `empty` is 1 is dropped. `dout` keeps its value and `empty` stays 1.
- R9: A reset edge takes precedence over a write or read requested in the same cycle. The result is the state of R1, with no byte stored.
- R10: `full` and `empty` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_wr_sel | input | 1 | 1 = read (pop), 0 = write (push) |
| din | input | 8 | Byte to push |
| dout | output | 8 | Registered byte from the last accepted pop |
| full | output | 1 | Eight bytes stored |
| empty | output | 1 | No byte stored |

## Verification
Two things can land on the same edge: reset together with a requested push or pop, and a boundary flag together with a request that the flag must block. The bench fills the stack and then asserts reset while the select asks for a write, and again while it asks for a read. It also keeps writing past full and reading past empty. After every edge, a queue model independently predicts the output and both flags, and the design is judged against those predictions. This shows that reset wins and that blocked requests leave the stack contents and `dout` untouched.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

    localparam int unsigned STK_DEPTH_DEF = 8;
    localparam int unsigned STK_WIDTH_DEF = 8;

    // Level of the select line
    typedef enum logic {
        SEL_WRITE = 1'b0,
        SEL_READ  = 1'b1
    } stk_sel_e;

    // Decoded action for one clock
    typedef struct packed {
        logic push;
        logic pop;
        logic blocked;
    } stk_act_t;

    function automatic stk_act_t decode_act(stk_sel_e sel, logic is_full, logic is_empty);
        stk_act_t a;
        a = '0;
        if (sel == SEL_READ) begin
            if (is_empty) a.blocked = 1'b1;
            else          a.pop     = 1'b1;
        end else begin
            if (is_full)  a.blocked = 1'b1;
            else          a.push    = 1'b1;
        end
        return a;
    endfunction

endpackage

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
    import lifo_pkg::*;
(
    input  logic     rd_wr_sel,
    input  logic     full,
    input  logic     empty,
    output stk_act_t act
);

    stk_sel_e sel;

    always_comb begin
        sel = stk_sel_e'(rd_wr_sel);
        act = decode_act(sel, full, empty);
    end

endmodule

// File: rtl/lifo_ptr.sv
module lifo_ptr
    import lifo_pkg::*;
#(
    parameter int unsigned DEPTH = STK_DEPTH_DEF,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_act_t         act,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DEPTH);

    always_ff @(posedge clk) begin
        if (rst)           count <= '0;
        else if (act.push) count <= count + CNT_ONE;
        else if (act.pop)  count <= count - CNT_ONE;
    end

    always_comb begin
        full  = (count == CNT_TOP);
        empty = (count == '0);
    end

    // R2
    count_up_chk: assert property (@(posedge clk) disable iff (rst)
        act.push |=> count == $past(count) + CNT_ONE);

    // R3
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        act.pop |=> count == $past(count) - CNT_ONE);

    // R7
    full_block_chk: assert property (@(posedge clk) disable iff (rst)
        (act.blocked && full) |=> (full && $stable(count)));

    // R8
    empty_block_chk: assert property (@(posedge clk) disable iff (rst)
        (act.blocked && empty) |=> empty);

endmodule

// File: rtl/lifo_store.sv
module lifo_store
    import lifo_pkg::*;
#(
    parameter int unsigned DEPTH = STK_DEPTH_DEF,
    parameter int unsigned WIDTH = STK_WIDTH_DEF,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_act_t         act,
    input  logic [CNT_W-1:0] count,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] slot_q [DEPTH];
    logic [CNT_W-1:0] cnt_dec;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [WIDTH-1:0] rd_byte;

    always_comb begin
        cnt_dec = count - CNT_W'(1);
        wr_idx  = count[IDX_W-1:0];
        rd_idx  = cnt_dec[IDX_W-1:0];
        rd_byte = slot_q[rd_idx];
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [WIDTH-1:0] q;
        always_ff @(posedge clk) begin
            if (act.push && (wr_idx == IDX_W'(g))) q <= din;
        end
        assign slot_q[g] = q;
    end

    always_ff @(posedge clk) begin
        if (rst)          dout <= '0;
        else if (act.pop) dout <= rd_byte;
    end

    // R8
    dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !act.pop |=> $stable(dout));

endmodule

// File: rtl/byte_stack.sv
module byte_stack
    import lifo_pkg::*;
#(
    parameter int unsigned DEPTH = STK_DEPTH_DEF,
    parameter int unsigned WIDTH = STK_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_wr_sel,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    stk_act_t         act;
    logic [CNT_W-1:0] count;

    lifo_ctrl u_ctrl (
        .rd_wr_sel (rd_wr_sel),
        .full      (full),
        .empty     (empty),
        .act       (act)
    );

    lifo_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .act   (act),
        .count (count),
        .full  (full),
        .empty (empty)
    );

    lifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .act   (act),
        .count (count),
        .din   (din),
        .dout  (dout)
    );

    // R9
    reset_prio_chk: assert property (@(posedge clk)
        rst |=> (empty && !full && dout == '0));

    // R5
    full_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(DEPTH - 1) && rd_wr_sel == SEL_WRITE) |=> full);

    // R6
    empty_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(1) && rd_wr_sel == SEL_READ) |=> empty);

endmodule

// File: tb/byte_stack_tb.sv
module byte_stack_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       full;
    logic       empty;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] q[$];
    logic [7:0] exp_dout = 8'h00;
    logic [7:0] lfsr = 8'hA5;

    always #2 clk = ~clk;

    byte_stack u_dut (
        .clk       (clk),
        .rst       (rst),
        .rd_wr_sel (sel),
        .din       (din),
        .dout      (dout),
        .full      (full),
        .empty     (empty)
    );

    task automatic chk(bit ok, string req, string what, int act_v, int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
        end
    endtask

    task automatic step(bit r, bit s, logic [7:0] d, string req);
        @(negedge clk);
        rst = r; sel = s; din = d;
        @(posedge clk);
        if (r) begin
            q.delete();
            exp_dout = 8'h00;
        end else if (s) begin
            if (q.size() > 0) exp_dout = q.pop_back();
        end else begin
            if (q.size() < 8) q.push_back(d);
        end
        #1;
        chk(dout == exp_dout, req, "dout", dout, exp_dout);
        chk(full == (q.size() == 8), "R5", "full", full, q.size() == 8);
        chk(empty == (q.size() == 0), "R6", "empty", empty, q.size() == 0);
        chk(!(full && empty), "R10", "full&empty", full && empty, 0);
    endtask

    initial begin
        // R1 reset state
        step(1, 0, 8'h00, "R1");
        step(1, 1, 8'h00, "R1");
        // R2 fill with 0..7
        for (int i = 0; i < 8; i++) step(0, 0, 8'(i), "R2");
        // R7 writes while full are dropped
        step(0, 0, 8'hAA, "R7");
        step(0, 0, 8'hBB, "R7");
        // R4 reversed order on read-back
        for (int i = 0; i < 8; i++) step(0, 1, 8'h00, "R4");
        // R8 reads while empty hold dout
        step(0, 1, 8'h55, "R8");
        step(0, 1, 8'h66, "R8");
        // R2 / R3 mixed traffic
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (lfsr[0]) step(0, 1, lfsr, "R3");
            else         step(0, 0, lfsr, "R2");
        end
        // R9 reset against a write, then against a read
        for (int i = 0; i < 5; i++) step(0, 0, 8'(8'h40 + i), "R2");
        step(1, 0, 8'h77, "R9");
        step(0, 1, 8'h00, "R9");
        for (int i = 0; i < 8; i++) step(0, 0, 8'(8'h80 + i), "R5");
        step(1, 1, 8'h00, "R9");
        step(0, 1, 8'h00, "R9");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule